// File: doc/BRIEF.md
# Trapezoidal Pulse Shaper

This block shapes a stream of digitized preamplifier pulses that decay exponentially. It takes one signed ADC sample on every clock and gives one shaped sample on every clock. A first stage cancels the preamplifier's exponential decay with a moving-window deconvolution. This turns every pulse into a rectangle whose width is the window length L. A second stage takes a running mean over K samples. This turns the rectangle into a symmetric trapezoid with K-sample edges.

The window length, the mean length (given as a power of two) and the reciprocal of the decay constant are configuration inputs. The reciprocal is an unsigned fraction with 16 fractional bits. The equal-weight part of the deconvolution sum is kept as an exact integer running sum, updated at the head and tail from a circular delay memory. It is scaled by the reciprocal only when it is used, so the recursion carries no rounding. A synchronous reset, or any change of configuration, clears all history. A valid flag marks the outputs whose windows hold only samples taken since that clear.

Top module: `trap_shaper`

## Requirements
- R1: On a clock edge where `rst` is high, `y_out` becomes 0 and `y_valid` becomes 0. No sample taken before that edge affects any later output.
- R2: Let X[n] be the n-th sample taken since the last clear, with X[n] = 0 for n < 0, and let c = `cfg_inv_tau`/65536. Then F[n] = 65536·(X[n] + c·ΣX[n−i] for i = 1..L−1 + (c−1)·X[n−L]). The output for sample n is `y_out` = floor(ΣF[n−j] for j = 0..K−1 / (K·65536)), with F[m] = 0 for m < 0.
- R3: A sample taken at clock edge e first shows in `y_out` just after edge e+1. That is two register stages.
- R4: With `cfg_inv_tau` = 0 and a step of height A, the outputs rise through K steps to exactly A. They hold A for L−K+1 consecutive samples, and from L+K−1 samples after the step they are exactly 0.
- R5: With an exponential pulse of time constant τ and `cfg_inv_tau` = round((1−e^(−1/τ))·65536), the flat top of the trapezoid stays within 1 % of the pulse amplitude. Once L+K−1 samples have passed since the pulse start, the output stays within 1 % of zero.
- R6: `y_valid` is high exactly for the outputs of samples n with n+1 ≥ L+K. Once high, it stays high until the next clear.
- R7: A clock edge where any configuration input differs from the value captured at the previous edge acts as a clear, with the same effect as R1. The sample on that edge is discarded, and the new configuration applies from the next sample.
- R8: `cfg_klog` must be in 1..6 and selects K = 2^`cfg_klog`. The division in R2 rounds toward minus infinity, also for negative sums.
- R9: With L = 256, K = 64, `cfg_inv_tau` = 65535 and full-scale inputs of either sign, the output still follows R2 with no wrap-around. L must satisfy K < L ≤ 256.
- R10: Over at least 3000 consecutive samples with no clear, the output still follows R2 exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 9 | Deconvolution window length L |
| cfg_klog | input | 3 | log2 of the mean length K |
| cfg_inv_tau | input | 16 | 1/τ as an unsigned fraction, 16 fractional bits |
| x_in | input | 14 | Signed ADC sample, two's complement |
| y_out | output | 24 | Signed shaped sample, in input units |
| y_valid | output | 1 | High once the windows are fully primed |

## Verification
A single impulse shows the latency and the exact placement of the positive and negative boxcar plateaus. A step with zero decay correction shows the trapezoid geometry: rise length, flat-top count and exact return to zero. An exponential pulse with a matched reciprocal shows that the deconvolution really removes the decay and leaves no tail. Long random streams, full-scale blocks at the largest window, negative odd impulses and a configuration change without a reset are each compared against a direct-convolution model. These separate recursion drift, width overflow, rounding direction and the clearing of history.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int FRAC = 16;

  function automatic int unsigned box_size(input int unsigned klog);
    return 32'd1 << klog;
  endfunction
endpackage

// File: rtl/trap_delay.sv
module trap_delay #(
  parameter int W     = 14,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic [W-1:0]               wr_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_off,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH)-1:0]   ptr
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_addr;

  // rd_off == 0 selects the oldest entry, i.e. a delay of DEPTH
  assign rd_addr = ptr - rd_off;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[ptr] <= wr_data;
      ptr      <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/trap_deconv.sv
module trap_deconv import trap_pkg::*; #(
  parameter int DW    = 14,
  parameter int L_MAX = 256,
  parameter int AW    = $clog2(L_MAX),
  parameter int MW    = DW + AW + 1,
  parameter int FW    = MW + FRAC + 2
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic signed [DW-1:0] x_in,
  input  logic [AW:0]          len,
  input  logic [FRAC-1:0]      inv_tau,
  output logic signed [FW-1:0] f_out,
  output logic [AW-1:0]        wr_ptr
);
  logic [DW-1:0]        tail_raw;
  logic signed [DW-1:0] tail;
  logic signed [DW-1:0] x_prev;
  logic signed [MW-1:0] mid_sum;
  logic signed [MW-1:0] mid_next;

  // equal-weight window: add the newest past sample, drop the one leaving
  function automatic logic signed [MW-1:0] window_step(
    input logic signed [MW-1:0] acc,
    input logic signed [DW-1:0] head,
    input logic signed [DW-1:0] gone);
    return acc + MW'(head) - MW'(gone);
  endfunction

  // Q.FRAC result: (x_new - x_tail) + c * (window + x_tail)
  function automatic logic signed [FW-1:0] deconv_f(
    input logic signed [DW-1:0] x_new,
    input logic signed [DW-1:0] x_tail,
    input logic signed [MW-1:0] win,
    input logic [FRAC-1:0]      c);
    logic signed [FW-1:0] diff, span, coef;
    diff = FW'(x_new) - FW'(x_tail);
    span = FW'(win) + FW'(x_tail);
    coef = FW'($signed({1'b0, c}));
    return (diff <<< FRAC) + span * coef;
  endfunction

  trap_delay #(.W(DW), .DEPTH(L_MAX)) hist_i (
    .clk     (clk),
    .clr     (clr),
    .wr_data (x_in),
    .rd_off  (len[AW-1:0]),
    .rd_data (tail_raw),
    .ptr     (wr_ptr)
  );

  assign tail     = $signed(tail_raw);
  assign mid_next = window_step(mid_sum, x_prev, tail);

  always_ff @(posedge clk) begin
    if (clr) begin
      x_prev  <= '0;
      mid_sum <= '0;
      f_out   <= '0;
    end else begin
      x_prev  <= x_in;
      mid_sum <= mid_next;
      f_out   <= deconv_f(x_in, tail, mid_next, inv_tau);
    end
  end
endmodule

// File: rtl/trap_boxcar.sv
module trap_boxcar import trap_pkg::*; #(
  parameter int FW    = 41,
  parameter int K_MAX = 64,
  parameter int OW    = 24,
  parameter int KW    = $clog2(K_MAX),
  parameter int KLW   = $clog2(KW + 1),
  parameter int BW    = FW + KW
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic signed [FW-1:0] f_in,
  input  logic [KLW-1:0]       klog,
  output logic signed [OW-1:0] y_out,
  output logic signed [BW-1:0] box_acc,
  output logic [KW-1:0]        box_ptr
);
  logic [FW-1:0]        old_raw;
  logic signed [BW-1:0] acc_next;
  logic [KW-1:0]        depth_sel;

  function automatic logic signed [BW-1:0] run_sum(
    input logic signed [BW-1:0] acc,
    input logic signed [FW-1:0] add,
    input logic signed [FW-1:0] sub);
    return acc + BW'(add) - BW'(sub);
  endfunction

  // floor division by K * 2^FRAC
  function automatic logic signed [OW-1:0] scale_out(
    input logic signed [BW-1:0] acc,
    input logic [KLW-1:0]       kl);
    logic signed [BW-1:0] q;
    q = acc >>> (FRAC + int'(kl));
    return OW'(q);
  endfunction

  assign depth_sel = KW'(box_size(int'(klog)));

  trap_delay #(.W(FW), .DEPTH(K_MAX)) fifo_i (
    .clk     (clk),
    .clr     (clr),
    .wr_data (f_in),
    .rd_off  (depth_sel),
    .rd_data (old_raw),
    .ptr     (box_ptr)
  );

  assign acc_next = run_sum(box_acc, f_in, $signed(old_raw));

  always_ff @(posedge clk) begin
    if (clr) begin
      box_acc <= '0;
      y_out   <= '0;
    end else begin
      box_acc <= acc_next;
      y_out   <= scale_out(acc_next, klog);
    end
  end
endmodule

// File: rtl/trap_shaper.sv
module trap_shaper import trap_pkg::*; #(
  parameter int DW    = 14,
  parameter int L_MAX = 256,
  parameter int K_MAX = 64,
  parameter int OW    = DW + $clog2(L_MAX) + 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [$clog2(L_MAX):0]              cfg_len,
  input  logic [$clog2($clog2(K_MAX)+1)-1:0]  cfg_klog,
  input  logic [FRAC-1:0]                     cfg_inv_tau,
  input  logic signed [DW-1:0]                x_in,
  output logic signed [OW-1:0]                y_out,
  output logic                                y_valid
);
  localparam int AW  = $clog2(L_MAX);
  localparam int LW  = AW + 1;
  localparam int KW  = $clog2(K_MAX);
  localparam int KLW = $clog2(KW + 1);
  localparam int MW  = DW + AW + 1;
  localparam int FW  = MW + FRAC + 2;
  localparam int BW  = FW + KW;
  localparam int CW  = LW + 1;

  logic [LW-1:0]        len_q;
  logic [KLW-1:0]       klog_q;
  logic [FRAC-1:0]      tau_q;
  logic                 cfg_chg;
  logic                 clr;
  logic [CW-1:0]        taken;
  logic [CW-1:0]        target;
  logic                 primed_q;
  logic signed [FW-1:0] f_w;
  logic [AW-1:0]        wr_ptr;
  logic [KW-1:0]        box_ptr;
  logic signed [BW-1:0] box_acc;

  assign cfg_chg = (cfg_len != len_q) || (cfg_klog != klog_q) || (cfg_inv_tau != tau_q);
  assign clr     = rst || cfg_chg;
  assign target  = CW'(len_q) + CW'(box_size(int'(klog_q)));

  always_ff @(posedge clk) begin
    len_q  <= cfg_len;
    klog_q <= cfg_klog;
    tau_q  <= cfg_inv_tau;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      taken    <= '0;
      primed_q <= 1'b0;
      y_valid  <= 1'b0;
    end else begin
      if (!(&taken)) taken <= taken + 1'b1;
      primed_q <= ({1'b0, taken} + 1'b1) >= {1'b0, target};
      y_valid  <= primed_q;
    end
  end

  trap_deconv #(.DW(DW), .L_MAX(L_MAX)) deconv_i (
    .clk     (clk),
    .clr     (clr),
    .x_in    (x_in),
    .len     (len_q),
    .inv_tau (tau_q),
    .f_out   (f_w),
    .wr_ptr  (wr_ptr)
  );

  trap_boxcar #(.FW(FW), .K_MAX(K_MAX), .OW(OW)) boxcar_i (
    .clk     (clk),
    .clr     (clr),
    .f_in    (f_w),
    .klog    (klog_q),
    .y_out   (y_out),
    .box_acc (box_acc),
    .box_ptr (box_ptr)
  );
endmodule

// File: rtl/trap_shaper_chk.sv
module trap_shaper_chk #(
  parameter int AW  = 8,
  parameter int LW  = 9,
  parameter int KW  = 6,
  parameter int KLW = 3,
  parameter int BW  = 47,
  parameter int OW  = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr,
  input logic                 cfg_chg,
  input logic                 y_valid,
  input logic signed [OW-1:0] y_out,
  input logic [LW-1:0]        len_q,
  input logic [KLW-1:0]       klog_q,
  input logic [AW-1:0]        wr_ptr,
  input logic [KW-1:0]        box_ptr,
  input logic signed [BW-1:0] box_acc
);
  logic [15:0] seen;
  int          need;

  always_ff @(posedge clk) begin
    if (clr) seen <= '0;
    else if (!(&seen)) seen <= seen + 1'b1;
  end

  assign need = int'(len_q) + (1 << klog_q) + 1;

  // R6: valid flag follows the sample count since the last clear
  p_valid_window_r6: assert property (@(posedge clk) disable iff (rst)
    y_valid == (int'(seen) >= need));

  // R6: once valid, stays valid until a clear
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (y_valid && !clr) |=> y_valid);

  // R7: a configuration change empties the output
  p_cfg_clear_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (!y_valid && y_out == '0));

  // R2: the sample history advances one slot per sample
  p_hist_advance_r2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> wr_ptr == $past(wr_ptr) + 1'b1);

  // R3: both delay lines move in lockstep, fixing the stage alignment
  p_ptr_lockstep_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ptr[KW-1:0] == box_ptr);

  // R8: the mean length stays in the legal range
  p_klog_range_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(klog_q) >= 1) && (int'(klog_q) <= KW));

  // R9: the running sum keeps a spare sign bit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    box_acc[BW-1] == box_acc[BW-2]);
endmodule

bind trap_shaper trap_shaper_chk #(
  .AW(AW), .LW(LW), .KW(KW), .KLW(KLW), .BW(BW), .OW(OW)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .clr     (clr),
  .cfg_chg (cfg_chg),
  .y_valid (y_valid),
  .y_out   (y_out),
  .len_q   (len_q),
  .klog_q  (klog_q),
  .wr_ptr  (wr_ptr),
  .box_ptr (box_ptr),
  .box_acc (box_acc)
);

// File: tb/trap_shaper_tb.sv
`timescale 1ns/1ps
module trap_shaper_tb_top;
  localparam int NMAX = 4096;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [8:0]         cfg_len = 9'd20;
  logic [2:0]         cfg_klog = 3'd2;
  logic [15:0]        cfg_inv_tau = '0;
  logic signed [13:0] x_in = '0;
  logic signed [23:0] y_out;
  logic               y_valid;

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     finished = 0;
  longint xs   [NMAX];
  longint fr   [NMAX];
  longint yexp [NMAX];
  longint ygot [NMAX];
  bit     vgot [NMAX];

  always #2 clk = ~clk;

  trap_shaper dut_i (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_klog(cfg_klog),
    .cfg_inv_tau(cfg_inv_tau), .x_in(x_in), .y_out(y_out), .y_valid(y_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint xat(input int n);
    return (n < 0) ? 64'sd0 : xs[n];
  endfunction

  task automatic clear_xs(input int n_len);
    for (int n = 0; n < n_len; n++) xs[n] = 0;
  endtask

  // clears (reset or config change), checks the cleared state, streams xs
  task automatic stream(input int L, input int kl, input longint c, input int N,
                        input bit use_rst, input string req);
    @(negedge clk);
    cfg_len = 9'(L); cfg_klog = 3'(kl); cfg_inv_tau = 16'(c);
    if (use_rst) begin rst = 1'b1; x_in = '0; end
    else x_in = 14'sd777;
    @(negedge clk);
    rst = 1'b0;
    check(y_out == 0 && y_valid == 1'b0, {req, " cleared state"}, longint'(y_out), 0);
    for (int n = 0; n < N + 2; n++) begin
      if (n >= 2) begin
        ygot[n-2] = longint'(y_out);
        vgot[n-2] = y_valid;
      end
      x_in = (n < N) ? 14'(xs[n]) : 14'sd0;
      @(negedge clk);
    end
  endtask

  // direct-convolution model, independent of the recursive form
  task automatic compare(input int N, input int L, input int kl, input longint c, input string req);
    int     bad_y = 0, bad_v = 0, first = -1;
    int     K = 1 << kl;
    longint s;
    for (int n = 0; n < N; n++) begin
      s = xat(n) * 65536;
      for (int i = 1; i < L; i++) s += c * xat(n - i);
      s += (c - 65536) * xat(n - L);
      fr[n] = s;
    end
    for (int n = 0; n < N; n++) begin
      s = 0;
      for (int j = 0; j < K; j++) if (n - j >= 0) s += fr[n-j];
      yexp[n] = s >>> (16 + kl);
      if (ygot[n] != yexp[n]) begin bad_y++; if (first < 0) first = n; end
      if (vgot[n] != (n + 1 >= L + K)) bad_v++;
    end
    if (first < 0) first = 0;
    check(bad_y == 0, {req, " model match"}, ygot[first], yexp[first]);
    check(bad_v == 0, "R6 valid window", bad_v, 0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check(y_out == 0, "R1 y_out after reset", longint'(y_out), 0);
    check(y_valid == 1'b0, "R1 y_valid after reset", longint'(y_valid), 0);
  endtask

  task automatic t_long_random;
    for (int n = 0; n < 3000; n++) xs[n] = longint'($urandom_range(0, 16383)) - 8192;
    stream(100, 5, 1234, 3000, 1'b1, "R1");
    compare(3000, 100, 5, 1234, "R10 R2");
    check(ygot[2999] == yexp[2999], "R10 final sample", ygot[2999], yexp[2999]);
  endtask

  task automatic t_impulse;
    clear_xs(40); xs[5] = 400;
    stream(20, 2, 0, 40, 1'b1, "R1");
    check(ygot[4] == 0,    "R3 before impulse", ygot[4], 0);
    check(ygot[5] == 100,  "R3 impulse arrival", ygot[5], 100);
    check(ygot[8] == 100,  "R2 plateau end", ygot[8], 100);
    check(ygot[9] == 0,    "R2 after plateau", ygot[9], 0);
    check(ygot[25] == -100,"R2 tail plateau", ygot[25], -100);
    check(vgot[22] == 1'b0,"R6 not yet valid", longint'(vgot[22]), 0);
    check(vgot[23] == 1'b1,"R6 first valid", longint'(vgot[23]), 1);
    compare(40, 20, 2, 0, "R1 R2");
  endtask

  task automatic t_floor;
    clear_xs(30); xs[3] = -3;
    stream(10, 1, 0, 30, 1'b1, "R1");
    check(ygot[3] == -2, "R8 floor negative", ygot[3], -2);
    check(ygot[4] == -2, "R8 floor negative second", ygot[4], -2);
    check(ygot[13] == 1, "R8 floor positive", ygot[13], 1);
    compare(30, 10, 1, 0, "R8");
  endtask

  task automatic t_step;
    int flat = 0, first_full = -1, late_bad = 0;
    for (int n = 0; n < 120; n++) xs[n] = (n >= 10) ? 1000 : 0;
    stream(40, 3, 0, 120, 1'b1, "R1");
    for (int n = 0; n < 120; n++) begin
      if (ygot[n] == 1000) begin flat++; if (first_full < 0) first_full = n; end
      if (n >= 10 + 40 + 8 - 1 && ygot[n] != 0) late_bad++;
    end
    check(flat == 40 - 8 + 1, "R4 flat-top length", flat, 33);
    check(first_full == 17, "R4 rise length", first_full, 17);
    check(ygot[10] == 125, "R4 first rise step", ygot[10], 125);
    check(late_bad == 0, "R4 return to zero", late_bad, 0);
  endtask

  task automatic t_expo;
    real    tau = 32.0;
    longint c;
    int     top_bad = 0, tail_bad = 0;
    c = longint'($rtoi((1.0 - $exp(-1.0 / tau)) * 65536.0 + 0.5));
    for (int n = 0; n < 160; n++)
      xs[n] = (n < 20) ? 0 : longint'($rtoi(6000.0 * $exp(-real'(n - 20) / tau) + 0.5));
    stream(64, 4, c, 160, 1'b1, "R1");
    for (int n = 35; n <= 83; n++) if (ygot[n] > 6060 || ygot[n] < 5940) top_bad++;
    for (int n = 99; n < 160; n++) if (ygot[n] > 60 || ygot[n] < -60) tail_bad++;
    check(top_bad == 0, "R5 flat top within 1%", top_bad, 0);
    check(tail_bad == 0, "R5 no tail", tail_bad, 0);
    compare(160, 64, 4, c, "R5 R2");
  endtask

  task automatic t_cfg_change;
    for (int n = 0; n < 30; n++) xs[n] = longint'($urandom_range(0, 4000)) - 2000;
    stream(20, 2, 0, 30, 1'b1, "R1");
    for (int n = 0; n < 60; n++) xs[n] = longint'($urandom_range(0, 4000)) - 2000;
    stream(24, 3, 500, 60, 1'b0, "R7");
    compare(60, 24, 3, 500, "R7");
  endtask

  task automatic t_fullscale;
    for (int n = 0; n < 800; n++)
      xs[n] = (n < 300) ? 8191 : (n < 600) ? -8192 : ((n % 2) ? 8191 : -8192);
    stream(256, 6, 65535, 800, 1'b1, "R1");
    compare(800, 256, 6, 65535, "R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_long_random();
    t_impulse();
    t_floor();
    t_step();
    t_expo();
    t_cfg_change();
    t_fullscale();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule